// File: doc/BRIEF.md
# Hardwired Instruction Sequencer

This block is the control sequencer of a small 32-bit processor whose registers share one internal bus. A step counter walks through timing steps T0, T1, T2 and onward, and every control strobe is formed as the AND of one step line with one decoded instruction-class line. In each step the sequencer names at most one bus source and at most one destination load. The datapath therefore performs exactly one register transfer per clock: the chosen source drives the bus, and the selected destination captures it on the closing edge. The block contains no datapath, no ALU and no memory.

Every instruction starts with the same three fetch steps. In the last of them the sequencer captures the six opcode bits of the incoming instruction word. The upper three bits pick one of eight classes, and the lower three carry an ALU operation or a branch condition. Execute steps begin at T3, and the last step of each class sends the counter back to T0. Memory accesses stretch their step until the memory reports ready. A build option selects either a one-hot shift register or a binary counter with a decoder as the step counter.

Top module: `hwcu_top`

## Requirements
- R1: While `rst` is high at a rising edge, every strobe output is 0 in that cycle. After `rst` falls, the first cycle is T0, and the captured opcode reads as 000000, so `cond_sel` is 0.
- R2: In T0, `bus_src[0]` (PC) and `reg_ld[0]` (MAR) are high and no other strobe is high. The following cycle is T1.
- R3: In T1, `mem_rd` is high. The step stays at T1 for as long as `mem_rdy` is low and moves to T2 on the first edge at which it is high.
- R4: In T2, `bus_src[1]` (MDR), `reg_ld[2]` (IR) and `pc_inc` are all high together. The value on `mdr_op` is captured at that edge as the current opcode.
- R5: An opcode of 000000 (no-op) returns the counter from T2 straight to T0, and no execute step is issued.
- R6: Classes 000 (register-register, nonzero low bits) and 001 (register-constant) issue three steps. T3 moves RS1 (`bus_src[2]`) into Y (`reg_ld[3]`). T4 moves RS2 (`bus_src[3]`, class 000) or IMM (`bus_src[4]`, class 001) into Z (`reg_ld[4]`), with `alu_op` equal to the low three opcode bits. T5 moves Z (`bus_src[5]`) into RD (`reg_ld[5]`) and ends the instruction. In every other cycle `alu_op` is 0.
- R7: Class 010 (load) runs RS1→Y at T3, IMM→Z at T4 and Z→MAR at T5. At T6 it raises `mem_rd` and holds there while `mem_rdy` is low. T7 runs MDR→RD and ends the instruction.
- R8: Class 011 (store) runs T3 to T5 as a load does and then RS2→MDR (`reg_ld[1]`) at T6. At T7 it raises `mem_wr`, holds there while `mem_rdy` is low, and ends the instruction when `mem_rdy` is high.
- R9: Class 100 (branch) runs PC→Y at T3 and IMM→Z at T4. At T5 Z drives the bus, and `reg_ld[6]` (PC) is high only when `cond_ok` is high. The instruction then ends. While the current opcode is of this class, `cond_sel` carries its low three bits; otherwise `cond_sel` is 0.
- R10: Class 101 (PC-relative jump) runs PC→Y at T3 and IMM→Z at T4, then Z→PC at T5 without any condition, and ends.
- R11: Class 110 (register-indirect jump) runs RS1→PC at T3 and ends.
- R12: Class 111 (jump-and-link) runs PC→LINK (`reg_ld[7]`) at T3, PC→Y at T4, IMM→Z at T5 and Z→PC at T6, then ends.
- R13: In every cycle at most one bit of `bus_src` is high and at most one bit of `reg_ld` is high, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mdr_op | input | OPC_W | Opcode bits (word bits 31:26) of the instruction being loaded into IR; sampled in T2 |
| mem_rdy | input | 1 | Memory has completed the current read or write |
| cond_ok | input | 1 | Datapath reports that the selected branch condition is true |
| bus_src | output | 6 | One-hot bus source: 0 PC, 1 MDR, 2 RS1, 3 RS2, 4 IMM, 5 Z |
| reg_ld | output | 8 | One-hot destination load: 0 MAR, 1 MDR, 2 IR, 3 Y, 4 Z, 5 RD, 6 PC, 7 LINK |
| mem_rd | output | 1 | Memory read strobe (memory into MDR) |
| mem_wr | output | 1 | Memory write strobe (MDR to memory) |
| pc_inc | output | 1 | Advance the PC by 4 through its own incrementer |
| alu_op | output | OPC_W-3 | ALU operation code while Z is loaded in an ALU-class step, else 0 |
| cond_sel | output | OPC_W-3 | Branch condition selector while a branch is current, else 0 |

## Verification
The bench builds two copies of the block and drives both with the same inputs. One uses the default one-hot counter of eight steps. The other uses the binary counter variant with eleven steps, so the wrap-free decode and the unused upper step lines are exercised next to the one-hot shift register. Both copies are compared every cycle against one behavioural model. The stimulus mixes all eight classes and no-ops, sweeps the condition input across branches, and includes a window in which memory is rarely ready, which produces long holds at T1, in the load read and in the store write. A reset is also applied in the middle of an instruction.

// File: rtl/hwcu_pkg.sv
package hwcu_pkg;
   localparam int SRC_W = 6;
   localparam int LD_W  = 8;

   localparam int SRC_PC  = 0;
   localparam int SRC_MDR = 1;
   localparam int SRC_RS1 = 2;
   localparam int SRC_RS2 = 3;
   localparam int SRC_IMM = 4;
   localparam int SRC_Z   = 5;

   localparam int LD_MAR  = 0;
   localparam int LD_MDR  = 1;
   localparam int LD_IR   = 2;
   localparam int LD_Y    = 3;
   localparam int LD_Z    = 4;
   localparam int LD_RD   = 5;
   localparam int LD_PC   = 6;
   localparam int LD_LINK = 7;

   localparam int MIN_STEPS = 8;

   typedef enum logic [2:0] {
      CLS_ALU_RR = 3'd0,
      CLS_ALU_RI = 3'd1,
      CLS_LOAD   = 3'd2,
      CLS_STORE  = 3'd3,
      CLS_BRANCH = 3'd4,
      CLS_JREL   = 3'd5,
      CLS_JIND   = 3'd6,
      CLS_JAL    = 3'd7
   } cls_e;
endpackage

// File: rtl/hwcu_step.sv
module hwcu_step #(
   parameter int STEPS  = 8,
   parameter bit ONEHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             restart,
   output logic [STEPS-1:0] t
);
   generate
      if (ONEHOT) begin : g_onehot
         logic [STEPS-1:0] t_q;
         always_ff @(posedge clk) begin
            if (rst || restart)
               t_q <= {{(STEPS-1){1'b0}}, 1'b1};
            else if (adv)
               t_q <= {t_q[STEPS-2:0], t_q[STEPS-1]};
         end
         assign t = t_q;
      end else begin : g_binary
         localparam int CW = $clog2(STEPS);
         logic [CW-1:0] c_q;
         always_ff @(posedge clk) begin
            if (rst || restart)
               c_q <= '0;
            else if (adv)
               c_q <= (c_q == CW'(STEPS-1)) ? '0 : c_q + 1'b1;
         end
         for (genvar i = 0; i < STEPS; i++) begin : g_dec
            assign t[i] = (c_q == CW'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/hwcu_decode.sv
module hwcu_decode #(
   parameter int OPC_W = 6,
   parameter int CLS_W = 3,
   localparam int SUB_W = OPC_W - CLS_W,
   localparam int NCLS  = 1 << CLS_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap,
   input  logic [OPC_W-1:0] op_in,
   output logic [NCLS-1:0]  cls,
   output logic [SUB_W-1:0] sub,
   output logic             nop_in
);
   logic [OPC_W-1:0] op_q;

   always_ff @(posedge clk) begin
      if (rst)
         op_q <= '0;
      else if (cap)
         op_q <= op_in;
   end

   generate
      for (genvar i = 0; i < NCLS; i++) begin : g_cls
         assign cls[i] = (op_q[OPC_W-1 -: CLS_W] == CLS_W'(i));
      end
   endgenerate

   assign sub    = op_q[SUB_W-1:0];
   assign nop_in = (op_in == '0);
endmodule

// File: rtl/hwcu_strobe.sv
module hwcu_strobe
   import hwcu_pkg::*;
#(
   parameter int STEPS = 8,
   parameter int NCLS  = 8,
   parameter int SUB_W = 3
) (
   input  logic             rst,
   input  logic [STEPS-1:0] t,
   input  logic [NCLS-1:0]  cls,
   input  logic [SUB_W-1:0] sub,
   input  logic             nop_in,
   input  logic             mem_rdy,
   input  logic             cond_ok,
   output logic [SRC_W-1:0] src,
   output logic [LD_W-1:0]  ld,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             pc_inc,
   output logic [SUB_W-1:0] alu_op,
   output logic [SUB_W-1:0] cond_sel,
   output logic             hold,
   output logic             last
);
   logic alu_c, mem_c, adr_c, pc_base;

   always_comb begin
      src      = '0;
      ld       = '0;
      mem_rd   = 1'b0;
      mem_wr   = 1'b0;
      pc_inc   = 1'b0;
      alu_op   = '0;
      cond_sel = '0;
      hold     = 1'b0;
      last     = 1'b0;

      alu_c   = cls[CLS_ALU_RR] | cls[CLS_ALU_RI];
      mem_c   = cls[CLS_LOAD] | cls[CLS_STORE];
      adr_c   = mem_c | cls[CLS_BRANCH] | cls[CLS_JREL];
      pc_base = cls[CLS_BRANCH] | cls[CLS_JREL];

      if (!rst) begin
         if (cls[CLS_BRANCH]) cond_sel = sub;

         // fetch
         if (t[0]) begin
            src[SRC_PC] = 1'b1;
            ld[LD_MAR]  = 1'b1;
         end
         if (t[1]) begin
            mem_rd = 1'b1;
            hold   = !mem_rdy;
         end
         if (t[2]) begin
            src[SRC_MDR] = 1'b1;
            ld[LD_IR]    = 1'b1;
            pc_inc       = 1'b1;
            last         = nop_in;
         end

         // ALU classes
         if (alu_c && t[3]) begin
            src[SRC_RS1] = 1'b1;
            ld[LD_Y]     = 1'b1;
         end
         if (alu_c && t[4]) begin
            src[SRC_RS2] = cls[CLS_ALU_RR];
            src[SRC_IMM] = cls[CLS_ALU_RI];
            ld[LD_Z]     = 1'b1;
            alu_op       = sub;
         end
         if (alu_c && t[5]) begin
            src[SRC_Z] = 1'b1;
            ld[LD_RD]  = 1'b1;
            last       = 1'b1;
         end

         // address-forming classes: base into Y, offset plus base into Z
         if (adr_c && t[3]) begin
            src[SRC_RS1] = mem_c;
            src[SRC_PC]  = pc_base;
            ld[LD_Y]     = 1'b1;
         end
         if (adr_c && t[4]) begin
            src[SRC_IMM] = 1'b1;
            ld[LD_Z]     = 1'b1;
         end

         // load and store
         if (mem_c && t[5]) begin
            src[SRC_Z] = 1'b1;
            ld[LD_MAR] = 1'b1;
         end
         if (cls[CLS_LOAD] && t[6]) begin
            mem_rd = 1'b1;
            hold   = !mem_rdy;
         end
         if (cls[CLS_LOAD] && t[7]) begin
            src[SRC_MDR] = 1'b1;
            ld[LD_RD]    = 1'b1;
            last         = 1'b1;
         end
         if (cls[CLS_STORE] && t[6]) begin
            src[SRC_RS2] = 1'b1;
            ld[LD_MDR]   = 1'b1;
         end
         if (cls[CLS_STORE] && t[7]) begin
            mem_wr = 1'b1;
            hold   = !mem_rdy;
            last   = mem_rdy;
         end

         // PC-relative transfers: branch is qualified by the condition
         if (pc_base && t[5]) begin
            src[SRC_Z] = 1'b1;
            ld[LD_PC]  = cls[CLS_JREL] | cond_ok;
            last       = 1'b1;
         end

         // register-indirect jump
         if (cls[CLS_JIND] && t[3]) begin
            src[SRC_RS1] = 1'b1;
            ld[LD_PC]    = 1'b1;
            last         = 1'b1;
         end

         // jump-and-link
         if (cls[CLS_JAL] && t[3]) begin
            src[SRC_PC] = 1'b1;
            ld[LD_LINK] = 1'b1;
         end
         if (cls[CLS_JAL] && t[4]) begin
            src[SRC_PC] = 1'b1;
            ld[LD_Y]    = 1'b1;
         end
         if (cls[CLS_JAL] && t[5]) begin
            src[SRC_IMM] = 1'b1;
            ld[LD_Z]     = 1'b1;
         end
         if (cls[CLS_JAL] && t[6]) begin
            src[SRC_Z] = 1'b1;
            ld[LD_PC]  = 1'b1;
            last       = 1'b1;
         end
      end
   end
endmodule

// File: rtl/hwcu_top.sv
module hwcu_top
   import hwcu_pkg::*;
#(
   parameter int OPC_W       = 6,
   parameter int CLS_W       = 3,
   parameter int STEPS       = 8,
   parameter bit ONEHOT_STEP = 1'b1,
   localparam int SUB_W = OPC_W - CLS_W,
   localparam int NCLS  = 1 << CLS_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] mdr_op,
   input  logic             mem_rdy,
   input  logic             cond_ok,
   output logic [SRC_W-1:0] bus_src,
   output logic [LD_W-1:0]  reg_ld,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             pc_inc,
   output logic [SUB_W-1:0] alu_op,
   output logic [SUB_W-1:0] cond_sel
);
   generate
      if (CLS_W != 3) begin : g_bad_cls
         $error("hwcu_top: eight instruction classes need CLS_W of 3");
      end
      if (SUB_W < 1) begin : g_bad_sub
         $error("hwcu_top: OPC_W must leave a subfield below the class bits");
      end
      if (STEPS < MIN_STEPS) begin : g_bad_steps
         $error("hwcu_top: the longest instruction needs at least eight steps");
      end
   endgenerate

   logic [STEPS-1:0] t;
   logic [NCLS-1:0]  cls;
   logic [SUB_W-1:0] sub;
   logic             nop_in, hold, last;

   hwcu_step #(.STEPS(STEPS), .ONEHOT(ONEHOT_STEP)) u_step (
      .clk     (clk),
      .rst     (rst),
      .adv     (!hold),
      .restart (last),
      .t       (t)
   );

   hwcu_decode #(.OPC_W(OPC_W), .CLS_W(CLS_W)) u_dec (
      .clk    (clk),
      .rst    (rst),
      .cap    (t[2]),
      .op_in  (mdr_op),
      .cls    (cls),
      .sub    (sub),
      .nop_in (nop_in)
   );

   hwcu_strobe #(.STEPS(STEPS), .NCLS(NCLS), .SUB_W(SUB_W)) u_strb (
      .rst      (rst),
      .t        (t),
      .cls      (cls),
      .sub      (sub),
      .nop_in   (nop_in),
      .mem_rdy  (mem_rdy),
      .cond_ok  (cond_ok),
      .src      (bus_src),
      .ld       (reg_ld),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .pc_inc   (pc_inc),
      .alu_op   (alu_op),
      .cond_sel (cond_sel),
      .hold     (hold),
      .last     (last)
   );
endmodule

// File: rtl/hwcu_chk.sv
module hwcu_chk
   import hwcu_pkg::*;
(
   input logic             clk,
   input logic             rst,
   input logic             mem_rdy,
   input logic [SRC_W-1:0] bus_src,
   input logic [LD_W-1:0]  reg_ld,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic             pc_inc
);
   always_ff @(posedge clk) begin
      if (rst) begin
         assert_reset_quiet_R1: assert (bus_src == '0 && reg_ld == '0 && !mem_rd && !mem_wr && !pc_inc)
            else $error("strobe active during reset");
      end
   end

   assert_fetch_then_read_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_src[SRC_PC] && reg_ld[LD_MAR]) |=> mem_rd);

   assert_read_held_R3: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && !mem_rdy) |=> mem_rd);

   assert_ir_with_inc_R4: assert property (@(posedge clk) disable iff (rst)
      reg_ld[LD_IR] |-> (pc_inc && bus_src[SRC_MDR]));

   assert_write_held_R8: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && !mem_rdy) |=> mem_wr);

   assert_link_from_pc_R12: assert property (@(posedge clk) disable iff (rst)
      reg_ld[LD_LINK] |-> bus_src[SRC_PC]);

   assert_one_source_R13: assert property (@(posedge clk) disable iff (rst)
      $onehot0(bus_src));

   assert_one_load_R13: assert property (@(posedge clk) disable iff (rst)
      $onehot0(reg_ld));

   assert_rw_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));
endmodule

bind hwcu_top hwcu_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .mem_rdy (mem_rdy),
   .bus_src (bus_src),
   .reg_ld  (reg_ld),
   .mem_rd  (mem_rd),
   .mem_wr  (mem_wr),
   .pc_inc  (pc_inc)
);

// File: tb/hwcu_top_tb_top.sv
`timescale 1ns/1ps
module hwcu_top_tb_top;
   import hwcu_pkg::*;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst;
   logic [5:0] mdr_op;
   logic       mem_rdy, cond_ok;

   logic [5:0] a_src, b_src;
   logic [7:0] a_ld, b_ld;
   logic       a_rd, a_wr, a_inc, b_rd, b_wr, b_inc;
   logic [2:0] a_alu, a_cs, b_alu, b_cs;

   hwcu_top #(.OPC_W(6), .STEPS(8), .ONEHOT_STEP(1'b1)) dut_i (
      .clk(clk), .rst(rst), .mdr_op(mdr_op), .mem_rdy(mem_rdy), .cond_ok(cond_ok),
      .bus_src(a_src), .reg_ld(a_ld), .mem_rd(a_rd), .mem_wr(a_wr), .pc_inc(a_inc),
      .alu_op(a_alu), .cond_sel(a_cs));

   hwcu_top #(.OPC_W(6), .STEPS(11), .ONEHOT_STEP(1'b0)) dut_b_i (
      .clk(clk), .rst(rst), .mdr_op(mdr_op), .mem_rdy(mem_rdy), .cond_ok(cond_ok),
      .bus_src(b_src), .reg_ld(b_ld), .mem_rd(b_rd), .mem_wr(b_wr), .pc_inc(b_inc),
      .alu_op(b_alu), .cond_sel(b_cs));

   int  vec = 0;
   int  mis = 0;
   bit  done = 1'b0;

   int         m_step, n_step;
   logic [5:0] m_op, n_op;
   logic [5:0] e_src;
   logic [7:0] e_ld;
   logic       e_rd, e_wr, e_inc;
   logic [2:0] e_alu, e_cs;
   string      tag;

   task automatic xfer(input int s, input int d);
      e_src[s] = 1'b1;
      e_ld[d]  = 1'b1;
   endtask

   task automatic model_eval();
      logic [2:0] c, sb;
      e_src = '0; e_ld = '0; e_rd = 0; e_wr = 0; e_inc = 0; e_alu = '0; e_cs = '0;
      n_step = m_step; n_op = m_op;
      c  = m_op[5:3];
      sb = m_op[2:0];
      if (rst) begin
         tag = "R1"; n_step = 0; n_op = '0;
      end else begin
         if (c == 3'd4) e_cs = sb;
         case (m_step)
            0: begin tag = "R2"; xfer(SRC_PC, LD_MAR); n_step = 1; end
            1: begin tag = "R3"; e_rd = 1; n_step = mem_rdy ? 2 : 1; end
            2: begin
               tag = (mdr_op == 6'd0) ? "R5" : "R4";
               xfer(SRC_MDR, LD_IR); e_inc = 1; n_op = mdr_op;
               n_step = (mdr_op == 6'd0) ? 0 : 3;
            end
            default: begin
               n_step = m_step + 1;
               case (c)
                  3'd0, 3'd1: begin
                     tag = "R6";
                     if (m_step == 3) xfer(SRC_RS1, LD_Y);
                     if (m_step == 4) begin xfer(c == 3'd0 ? SRC_RS2 : SRC_IMM, LD_Z); e_alu = sb; end
                     if (m_step == 5) begin xfer(SRC_Z, LD_RD); n_step = 0; end
                  end
                  3'd2: begin
                     tag = "R7";
                     if (m_step == 3) xfer(SRC_RS1, LD_Y);
                     if (m_step == 4) xfer(SRC_IMM, LD_Z);
                     if (m_step == 5) xfer(SRC_Z, LD_MAR);
                     if (m_step == 6) begin e_rd = 1; n_step = mem_rdy ? 7 : 6; end
                     if (m_step == 7) begin xfer(SRC_MDR, LD_RD); n_step = 0; end
                  end
                  3'd3: begin
                     tag = "R8";
                     if (m_step == 3) xfer(SRC_RS1, LD_Y);
                     if (m_step == 4) xfer(SRC_IMM, LD_Z);
                     if (m_step == 5) xfer(SRC_Z, LD_MAR);
                     if (m_step == 6) xfer(SRC_RS2, LD_MDR);
                     if (m_step == 7) begin e_wr = 1; n_step = mem_rdy ? 0 : 7; end
                  end
                  3'd4, 3'd5: begin
                     tag = (c == 3'd4) ? "R9" : "R10";
                     if (m_step == 3) xfer(SRC_PC, LD_Y);
                     if (m_step == 4) xfer(SRC_IMM, LD_Z);
                     if (m_step == 5) begin
                        e_src[SRC_Z] = 1'b1;
                        e_ld[LD_PC]  = (c == 3'd5) || cond_ok;
                        n_step = 0;
                     end
                  end
                  3'd6: begin
                     tag = "R11";
                     xfer(SRC_RS1, LD_PC); n_step = 0;
                  end
                  default: begin
                     tag = "R12";
                     if (m_step == 3) xfer(SRC_PC, LD_LINK);
                     if (m_step == 4) xfer(SRC_PC, LD_Y);
                     if (m_step == 5) xfer(SRC_IMM, LD_Z);
                     if (m_step == 6) begin xfer(SRC_Z, LD_PC); n_step = 0; end
                  end
               endcase
            end
         endcase
      end
   endtask

   task automatic compare(input string which, input logic [5:0] s, input logic [7:0] l,
                          input logic r, input logic w, input logic i,
                          input logic [2:0] a, input logic [2:0] cs);
      vec++;
      if (s !== e_src || l !== e_ld || r !== e_rd || w !== e_wr || i !== e_inc ||
          a !== e_alu || cs !== e_cs) begin
         mis++;
         $display("FAIL %s %s step %0d t=%0t: actual src=%h ld=%h rd=%b wr=%b inc=%b alu=%0d cs=%0d expected src=%h ld=%h rd=%b wr=%b inc=%b alu=%0d cs=%0d",
                  tag, which, m_step, $time, s, l, r, w, i, a, cs,
                  e_src, e_ld, e_rd, e_wr, e_inc, e_alu, e_cs);
      end
      vec++;
      if (!$onehot0(s) || !$onehot0(l) || (r && w)) begin
         mis++;
         $display("FAIL R13 %s t=%0t: actual src=%h ld=%h rd=%b wr=%b expected one source, one load, no read with write",
                  which, $time, s, l, r, w);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         mis++;
         $display("FAIL R3 watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      logic [5:0]  cur_op;
      int          k;
      lfsr = 16'hACE1; k = 0; cur_op = '0;
      rst = 1'b1; mdr_op = '0; mem_rdy = 1'b1; cond_ok = 1'b0;
      m_step = 0; m_op = '0;
      for (int cyc = 0; cyc < 6000; cyc++) begin
         @(negedge clk);
         rst  = (cyc < 3) || (cyc >= 3000 && cyc < 3002);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (cyc >= 1000 && cyc < 1200) mem_rdy = lfsr[0] & lfsr[1] & lfsr[2];
         else                           mem_rdy = lfsr[0] | lfsr[1];
         cond_ok = lfsr[5];
         if (m_step == 0) begin
            k++;
            cur_op = {k[2:0], lfsr[9:7]};
            if (k % 5 == 0) cur_op = '0;
         end
         mdr_op = cur_op;
         #1;
         model_eval();
         compare("onehot", a_src, a_ld, a_rd, a_wr, a_inc, a_alu, a_cs);
         compare("binary", b_src, b_ld, b_rd, b_wr, b_inc, b_alu, b_cs);
         @(posedge clk);
         m_step = n_step;
         m_op   = n_op;
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
   end
endmodule